// File: doc/BRIEF.md
# Event Timer with Zero-Write-Clear Status

An up-counting timer with one compare channel and one capture channel, both working alongside wrap detection. The counter runs while a control bit is set, wraps to zero after a programmable reload value and raises an update flag. The compare channel raises a flag when the count equals its compare value. The capture channel synchronises an external input, detects its rising edges, stores the count and raises its own flag. A single-cycle register bus gives access to the control, count, reload, compare, capture, status and interrupt-enable registers. One interrupt line is active while any enabled flag is set.

The status flags clear only where a write carries a zero. Writing a one leaves a bit unchanged. Software therefore clears one event with a single write that has zero in that bit and ones everywhere else. It needs no read-modify-write, so an event raised by hardware between a read and a write is never lost. When a hardware event and a clear hit the same bit in the same cycle, the event wins.

The run control is a two-state machine, `CNT_IDLE` and `CNT_COUNT`:
- A control write with run=1 moves it from `CNT_IDLE` to `CNT_COUNT`.
- A control write with run=0 moves it from `CNT_COUNT` to `CNT_IDLE`.
- Any other cycle holds the current state.
- In `CNT_COUNT` the counter takes one of two actions each cycle: increment, or wrap to zero when the count equals the reload value.

The capture input is tracked by an edge machine with states `IN_LOW` and `IN_HIGH`. When the synchronised input is 1 in `IN_LOW`, that is a rising edge and the capture happens. The machine then follows the synchronised input.

Top module: `tmr_wzc_top`

## Requirements
- R1: After reset every register reads 0 except RELOAD, which reads 0xFFFF, and `irq` is 0. Register addresses are: CTRL=0 (bit 0 = run), COUNT=1, RELOAD=2, CMP=3, CAP=4 (read only), STATUS=5, IEN=6.
- R2: While CTRL bit 0 is 1 the count rises by one every clock. While it is 0 the count holds. A CTRL write takes effect at the edge that accepts it.
- R3: When the count equals RELOAD while running, the next edge sets the count to 0 and sets STATUS bit 0 (update).
- R4: When the count equals CMP while running, the next edge sets STATUS bit 1 (compare).
- R5: A rising edge on `cap_in` passes through a two-flop synchroniser. It then copies the count into CAP and sets STATUS bit 3 (capture). An input held high captures only once.
- R6: A STATUS write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R7: When a hardware event and a clearing STATUS write hit the same flag in the same cycle, the flag ends at 1. The other flags follow R6.
- R8: STATUS bit 2 and bits 15..4 always read 0. A STATUS write never sets a flag. IEN stores only bits 0, 1 and 3.
- R9: `irq` is 1 exactly while some STATUS flag and the IEN bit at the same position are both 1. It stays 1 until every enabled flag is cleared.
- R10: Reading any register, with the bus held across clock edges, changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt, OR of enabled flags |

## Verification
The hardest case to reach is a hardware event landing in the very cycle that a clearing STATUS write is accepted. The bench reaches it by stopping the counter and loading COUNT equal to CMP. It then issues the CTRL run write and the STATUS clear write back to back. This places the compare match in the first running cycle, which is exactly the cycle of the clear. A capture flag set beforehand shows that the ones in that write left the other flag alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 3;
    localparam int FLAG_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP    = 3'd4;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;
    localparam logic [ADDR_W-1:0] A_IEN    = 3'd6;

    // flag positions software decodes
    localparam int F_UPD = 0;
    localparam int F_CMP = 1;
    localparam int F_CAP = 3;
    localparam logic [FLAG_W-1:0] FLAG_MASK = 4'b1011;

    typedef enum logic {
        CNT_IDLE  = 1'b0,
        CNT_COUNT = 1'b1
    } cnt_state_e;

    typedef enum logic {
        IN_LOW  = 1'b0,
        IN_HIGH = 1'b1
    } edge_state_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_run,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] cmp,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             upd_evt,
    output logic             cmp_evt
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE:  if (ctrl_wr && ctrl_run)  state_d = CNT_COUNT;
            CNT_COUNT: if (ctrl_wr && !ctrl_run) state_d = CNT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_IDLE;
        else        state_q <= state_d;
    end

    // outputs and count datapath
    always_comb begin
        running = (state_q == CNT_COUNT);
        upd_evt = running && (cnt_q == reload);
        cmp_evt = running && (cnt_q == cmp);
        cnt_d   = cnt_q;
        if (load_en)      cnt_d = load_val;
        else if (upd_evt) cnt_d = '0;
        else if (running) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_evt
);
    logic [SYNC_N-1:0] sync_q;
    edge_state_e       edge_q, edge_d;
    logic [CNT_W-1:0]  cap_q;
    logic              in_s;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], cap_in};
    end
    assign in_s = sync_q[SYNC_N-1];

    always_comb begin
        edge_d  = edge_q;
        cap_evt = 1'b0;
        unique case (edge_q)
            IN_LOW: if (in_s) begin
                edge_d  = IN_HIGH;
                cap_evt = 1'b1;
            end
            IN_HIGH: if (!in_s) edge_d = IN_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= IN_LOW;
        else        edge_q <= edge_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= cnt;
    end

    assign cap_val = cap_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              running,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  cap_val,
    input  logic              upd_evt,
    input  logic              cmp_evt,
    input  logic              cap_evt,
    output logic              ctrl_wr,
    output logic              count_wr,
    output logic [CNT_W-1:0]  reload_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [FLAG_W-1:0] ien_q,
    output logic [FLAG_W-1:0] flags_q
);
    localparam int PAD_W = CNT_W - FLAG_W;

    logic              wr_any, st_wr;
    logic [FLAG_W-1:0] set_vec;

    assign wr_any   = bus_sel && bus_wr;
    assign ctrl_wr  = wr_any && (bus_addr == A_CTRL);
    assign count_wr = wr_any && (bus_addr == A_COUNT);
    assign st_wr    = wr_any && (bus_addr == A_STATUS);

    always_comb begin
        set_vec        = '0;
        set_vec[F_UPD] = upd_evt;
        set_vec[F_CMP] = cmp_evt;
        set_vec[F_CAP] = cap_evt;
    end

    // zero-write-clear flags, hardware set takes priority
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        if (FLAG_MASK[i]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= (bit_q && !(st_wr && !bus_wdata[i])) || set_vec[i];
            end
            assign flags_q[i] = bit_q;
        end else begin : g_rsvd
            assign flags_q[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
            cmp_q    <= '0;
            ien_q    <= '0;
        end else if (wr_any) begin
            if (bus_addr == A_RELOAD) reload_q <= bus_wdata;
            if (bus_addr == A_CMP)    cmp_q    <= bus_wdata;
            if (bus_addr == A_IEN)    ien_q    <= bus_wdata[FLAG_W-1:0] & FLAG_MASK;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:   bus_rdata = {{(CNT_W-1){1'b0}}, running};
            A_COUNT:  bus_rdata = cnt;
            A_RELOAD: bus_rdata = reload_q;
            A_CMP:    bus_rdata = cmp_q;
            A_CAP:    bus_rdata = cap_val;
            A_STATUS: bus_rdata = {{PAD_W{1'b0}}, flags_q};
            A_IEN:    bus_rdata = {{PAD_W{1'b0}}, ien_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_wzc_top.sv
module tmr_wzc_top
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cap_in,
    output logic              irq
);
    logic              running, upd_evt, cmp_evt, cap_evt;
    logic              ctrl_wr, count_wr;
    logic [CNT_W-1:0]  cnt, cap_val, reload_q, cmp_q;
    logic [FLAG_W-1:0] ien_q, flags_q;

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_run (bus_wdata[0]),
        .load_en  (count_wr),
        .load_val (bus_wdata),
        .reload   (reload_q),
        .cmp      (cmp_q),
        .running  (running),
        .cnt      (cnt),
        .upd_evt  (upd_evt),
        .cmp_evt  (cmp_evt)
    );

    tmr_capture #(.CNT_W(CNT_W), .SYNC_N(2)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_in  (cap_in),
        .cnt     (cnt),
        .cap_val (cap_val),
        .cap_evt (cap_evt)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .running   (running),
        .cnt       (cnt),
        .cap_val   (cap_val),
        .upd_evt   (upd_evt),
        .cmp_evt   (cmp_evt),
        .cap_evt   (cap_evt),
        .ctrl_wr   (ctrl_wr),
        .count_wr  (count_wr),
        .reload_q  (reload_q),
        .cmp_q     (cmp_q),
        .ien_q     (ien_q),
        .flags_q   (flags_q)
    );

    assign irq = |(flags_q & ien_q);
endmodule

// File: rtl/tmr_wzc_chk.sv
module tmr_wzc_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] ien,
    input logic              irq,
    input logic              upd_evt,
    input logic              cmp_evt,
    input logic              cap_evt,
    input logic [CNT_W-1:0]  cnt
);
    logic st_wr, cnt_wr, ien_wr;
    assign st_wr  = bus_sel && bus_wr && (bus_addr == A_STATUS);
    assign cnt_wr = bus_sel && bus_wr && (bus_addr == A_COUNT);
    assign ien_wr = bus_sel && bus_wr && (bus_addr == A_IEN);

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && !cnt_wr) |=> (cnt == '0 && flags[F_UPD]));

    assert_one_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && bus_wdata[F_UPD] && flags[F_UPD]) |=> flags[F_UPD]);

    assert_zero_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !bus_wdata[F_CAP] && !cap_evt) |=> !flags[F_CAP]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !bus_wdata[F_CMP] && cmp_evt) |=> flags[F_CMP]);

    assert_no_write_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !upd_evt) |=> !$rose(flags[F_UPD]));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STATUS) |-> ((bus_rdata & ~{{(CNT_W-FLAG_W){1'b0}}, FLAG_MASK}) == '0));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & ien) != '0));

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !st_wr && !ien_wr) |=> irq);
endmodule

bind tmr_wzc_top tmr_wzc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flags     (flags_q),
    .ien       (ien_q),
    .irq       (irq),
    .upd_evt   (upd_evt),
    .cmp_evt   (cmp_evt),
    .cap_evt   (cap_evt),
    .cnt       (cnt)
);

// File: tb/tmr_wzc_top_bench.sv
module tmr_wzc_top_bench;
    localparam logic [2:0] R_CTRL = 3'd0, R_COUNT = 3'd1, R_RELOAD = 3'd2,
                           R_CMP = 3'd3, R_CAP = 3'd4, R_STATUS = 3'd5, R_IEN = 3'd6;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, cap_in = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    tmr_wzc_top #(.CNT_W(16)) u_tmr_wzc_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // combinational read, consumes no clock
    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_cap();
        cap_in = 1'b0; repeat (4) @(negedge clk);
        cap_in = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(R_CTRL, v);   chk("R1 ctrl", v, 16'h0000);
        rd(R_COUNT, v);  chk("R1 count", v, 16'h0000);
        rd(R_RELOAD, v); chk("R1 reload", v, 16'hFFFF);
        rd(R_CMP, v);    chk("R1 cmp", v, 16'h0000);
        rd(R_CAP, v);    chk("R1 cap", v, 16'h0000);
        rd(R_STATUS, v); chk("R1 status", v, 16'h0000);
        rd(R_IEN, v);    chk("R1 ien", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_count();
        logic [15:0] v;
        wr(R_RELOAD, 16'h00FF); wr(R_CMP, 16'hFFFF); wr(R_COUNT, 16'h0000);
        wr(R_CTRL, 16'h0001);
        repeat (5) @(negedge clk);
        rd(R_COUNT, v); chk("R2 count after 5", v, 16'd5);
        wr(R_CTRL, 16'h0000);
        rd(R_CTRL, v); chk("R2 stopped", v, 16'h0000);
        repeat (3) @(negedge clk);
        rd(R_COUNT, v); chk("R2 count holds", v, 16'd6);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        wr(R_RELOAD, 16'd3); wr(R_COUNT, 16'd0); wr(R_STATUS, 16'h0000);
        wr(R_CTRL, 16'h0001);
        repeat (3) @(negedge clk);
        rd(R_COUNT, v);  chk("R3 at reload", v, 16'd3);
        rd(R_STATUS, v); chk("R3 no update yet", v, 16'h0000);
        @(negedge clk);
        rd(R_COUNT, v);  chk("R3 wrapped", v, 16'd0);
        rd(R_STATUS, v); chk("R3 update flag", v, 16'h0001);
        wr(R_CTRL, 16'h0000);
    endtask

    task automatic t_compare();
        logic [15:0] v;
        wr(R_RELOAD, 16'd100); wr(R_COUNT, 16'd0); wr(R_CMP, 16'd10);
        wr(R_STATUS, 16'h0000);
        wr(R_CTRL, 16'h0001);
        repeat (10) @(negedge clk);
        rd(R_STATUS, v); chk("R4 before match", v, 16'h0000);
        @(negedge clk);
        rd(R_STATUS, v); chk("R4 compare flag", v, 16'h0002);
        wr(R_CTRL, 16'h0000);
        wr(R_STATUS, 16'h0000);
    endtask

    task automatic t_capture();
        logic [15:0] v;
        wr(R_COUNT, 16'h1234);
        cap_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(R_CAP, v);    chk("R5 captured", v, 16'h1234);
        rd(R_STATUS, v); chk("R5 capture flag", v, 16'h0008);
        wr(R_COUNT, 16'h0055);
        repeat (4) @(negedge clk);
        rd(R_CAP, v);    chk("R5 held high no recapture", v, 16'h1234);
        pulse_cap();
        rd(R_CAP, v);    chk("R5 second edge", v, 16'h0055);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(R_RELOAD, 16'd5); wr(R_COUNT, 16'd5); wr(R_CMP, 16'd5);
        wr(R_CTRL, 16'h0001); wr(R_CTRL, 16'h0000);
        rd(R_STATUS, v); chk("R6 three flags", v, 16'h000B);
        wr(R_STATUS, 16'hFFFD);
        rd(R_STATUS, v); chk("R6 clear compare only", v, 16'h0009);
        wr(R_STATUS, 16'hFFFF);
        rd(R_STATUS, v); chk("R6 ones no effect", v, 16'h0009);
        wr(R_STATUS, 16'hFFF7);
        rd(R_STATUS, v); chk("R6 clear capture only", v, 16'h0001);
        wr(R_STATUS, 16'hFFFE);
        rd(R_STATUS, v); chk("R6 clear update", v, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        pulse_cap();
        wr(R_RELOAD, 16'hFFFF); wr(R_CMP, 16'd7); wr(R_COUNT, 16'd7);
        wr(R_CTRL, 16'h0001);
        wr(R_STATUS, 16'hFFFD); // match and clear in the same cycle
        rd(R_STATUS, v); chk("R7 set beats clear, capture kept", v, 16'h000A);
        wr(R_CTRL, 16'h0000);
        wr(R_STATUS, 16'hFFF7);
        rd(R_STATUS, v); chk("R7 later clear of capture", v, 16'h0002);
        wr(R_STATUS, 16'h0000);
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        wr(R_STATUS, 16'hFFFF);
        rd(R_STATUS, v); chk("R8 write never sets", v, 16'h0000);
        wr(R_IEN, 16'hFFFF);
        rd(R_IEN, v);    chk("R8 ien implemented bits", v, 16'h000B);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        chk("R9 idle irq", {15'd0, irq}, 16'h0000);
        wr(R_RELOAD, 16'd5); wr(R_COUNT, 16'd5); wr(R_CMP, 16'd5);
        wr(R_CTRL, 16'h0001); wr(R_CTRL, 16'h0000);
        wr(R_IEN, 16'h0001);
        chk("R9 update enabled", {15'd0, irq}, 16'h0001);
        wr(R_STATUS, 16'hFFFE);
        chk("R9 only disabled flag left", {15'd0, irq}, 16'h0000);
        wr(R_IEN, 16'h0003);
        chk("R9 compare enabled", {15'd0, irq}, 16'h0001);
        wr(R_STATUS, 16'hFFFD);
        chk("R9 all cleared", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_reads();
        logic [15:0] v;
        pulse_cap();
        for (int a = 0; a < 7; a++) begin
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
            @(posedge clk); @(negedge clk);
        end
        bus_sel = 1'b0;
        rd(R_STATUS, v); chk("R10 reads no side effect", v, 16'h0008);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_wrap();
        t_compare();
        t_capture();
        t_clear();
        t_set_wins();
        t_reserved();
        t_irq();
        t_reads();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule